// File: doc/BRIEF.md
# Eight-bit minifloat to single-precision widener

This block turns a compact one-byte floating-point number into a 32-bit IEEE-754 single-precision word. The byte carries a sign, a three-bit exponent with bias 3 and a four-bit fraction. Normal values have an implied leading one. Exponent code zero marks zero or unnormalized values. The all-ones exponent code always means NaN and never infinity. The widener re-biases normal exponents and renormalizes unnormalized inputs, which become ordinary normal singles. It maps NaN codes to a single-precision NaN, and it left-aligns the fraction in the wider fraction field.

The block is a single registered pipeline stage. A byte presented with its valid strobe produces the wide word, with its valid strobe, on the following clock. The output word holds its last value while no new byte arrives. The block performs no arithmetic and no rounding, and it has no reverse path.

Top module: `mfw_widen`

## Requirements
- R1: Output bit 31 equals input bit 7 (sign) for every input code.
- R2: For an input exponent (bits 6..4) between 1 and 6, output bits 30..23 equal that exponent plus 124.
- R3: For such normal inputs, input bits 3..0 appear at output bits 22..19 and output bits 18..0 are zero.
- R4: An input with exponent 000 and fraction 0000 gives output bits 30..0 all zero.
- R5: An input with exponent 000 and a nonzero fraction is renormalized. Call the shift count s, the number of left shifts (1 to 4) that moves the highest set fraction bit out of the fraction. The output exponent is 125 − s. The four fraction bits left after the shift go to bits 22..19, and bits 18..0 are zero.
- R6: An input with exponent 111 gives output exponent 255. Output bit 22 is 1, input bits 2..0 appear at bits 21..19, and bits 18..0 are zero, so the result is always NaN.
- R7: out_valid equals the in_valid sampled at the previous rising edge, and out_word carries the conversion of the byte accepted at that edge.
- R8: While in_valid is low at a rising edge, out_word keeps its value across that edge.
- R9: A synchronous active-high reset drives out_valid and out_word to zero at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte is valid this cycle |
| in_byte | input | 8 | Minifloat: sign [7], exponent [6:4], fraction [3:0] |
| out_valid | output | 1 | out_word holds a fresh conversion |
| out_word | output | 32 | Single-precision result |

## Verification
The bench builds the block with its default widths: a 3-bit exponent, a 4-bit fraction and an 8-bit/23-bit single-precision target. With these widths the whole input space is only 256 codes. Every code is driven back to back, and every code is driven again with idle gaps between them. Every reserved exponent code and every shift count of the renormalization path is therefore compared against the behavioural model. A reset applied while valid data is streaming confirms that the register clears.

// File: rtl/mfw_pkg.sv
package mfw_pkg;
   typedef enum logic [1:0] {
      CLS_ZERO = 2'd0,
      CLS_SUB  = 2'd1,
      CLS_NORM = 2'd2,
      CLS_NAN  = 2'd3
   } mfw_class_e;
endpackage

// File: rtl/mfw_classify.sv
module mfw_classify
   import mfw_pkg::*;
#(
   parameter int EXP_W  = 3,
   parameter int FRAC_W = 4
) (
   input  logic [EXP_W-1:0]  exp_code,
   input  logic [FRAC_W-1:0] frac_code,
   output mfw_class_e        cls
);
   always_comb begin
      if (exp_code == '0)
         cls = (frac_code == '0) ? CLS_ZERO : CLS_SUB;
      else if (exp_code == {EXP_W{1'b1}})
         cls = CLS_NAN;
      else
         cls = CLS_NORM;
   end
endmodule

// File: rtl/mfw_subnorm.sv
module mfw_subnorm #(
   parameter int FRAC_W   = 4,
   parameter int DEXP_W   = 8,
   parameter int SUB_BASE = 125
) (
   input  logic [FRAC_W-1:0] frac_code,
   output logic [DEXP_W-1:0] exp_out,
   output logic [FRAC_W-1:0] frac_out
);
   localparam int SH_W = $clog2(FRAC_W + 1);

   logic [SH_W-1:0] shift;

   // shift count: distance of the highest set bit from just above the field
   always_comb begin
      shift = '0;
      for (int i = 0; i < FRAC_W; i++)
         if (frac_code[i]) shift = SH_W'(FRAC_W - i);
   end

   assign frac_out = frac_code << shift;
   assign exp_out  = DEXP_W'(SUB_BASE) - DEXP_W'(shift);
endmodule

// File: rtl/mfw_pack.sv
module mfw_pack
   import mfw_pkg::*;
#(
   parameter int EXP_W     = 3,
   parameter int FRAC_W    = 4,
   parameter int DEXP_W    = 8,
   parameter int DFRAC_W   = 23,
   parameter int BIAS_DIFF = 124,
   localparam int OUT_W    = 1 + DEXP_W + DFRAC_W
) (
   input  logic               sign,
   input  logic [EXP_W-1:0]   exp_code,
   input  logic [FRAC_W-1:0]  frac_code,
   input  mfw_class_e         cls,
   input  logic [DEXP_W-1:0]  sub_exp,
   input  logic [FRAC_W-1:0]  sub_frac,
   output logic [OUT_W-1:0]   word
);
   localparam int PAD = DFRAC_W - FRAC_W;

   logic [DEXP_W-1:0]  exp_sel;
   logic [FRAC_W-1:0]  frac_sel;
   logic [DFRAC_W-1:0] frac_wide;

   always_comb begin
      unique case (cls)
         CLS_ZERO: begin exp_sel = '0;                 frac_sel = '0; end
         CLS_SUB:  begin exp_sel = sub_exp;            frac_sel = sub_frac; end
         CLS_NAN:  begin exp_sel = {DEXP_W{1'b1}};
                         frac_sel = {1'b1, frac_code[FRAC_W-2:0]}; end
         default:  begin exp_sel = DEXP_W'(exp_code) + DEXP_W'(BIAS_DIFF);
                         frac_sel = frac_code; end
      endcase
   end

   generate
      if (PAD > 0) begin : g_pad
         assign frac_wide = {frac_sel, {PAD{1'b0}}};
      end else begin : g_nopad
         assign frac_wide = frac_sel;
      end
   endgenerate

   assign word = {sign, exp_sel, frac_wide};
endmodule

// File: rtl/mfw_widen.sv
module mfw_widen
   import mfw_pkg::*;
#(
   parameter int EXP_W   = 3,
   parameter int FRAC_W  = 4,
   parameter int DEXP_W  = 8,
   parameter int DFRAC_W = 23,
   localparam int IN_W   = 1 + EXP_W + FRAC_W,
   localparam int OUT_W  = 1 + DEXP_W + DFRAC_W
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic [IN_W-1:0]  in_byte,
   output logic             out_valid,
   output logic [OUT_W-1:0] out_word
);
   localparam int SRC_BIAS  = (1 << (EXP_W - 1)) - 1;
   localparam int DST_BIAS  = (1 << (DEXP_W - 1)) - 1;
   localparam int BIAS_DIFF = DST_BIAS - SRC_BIAS;
   localparam int SUB_BASE  = BIAS_DIFF + 1;

   generate
      if (EXP_W < 2 || FRAC_W < 2)
         $error("mfw_widen: source fields too narrow");
      if (DEXP_W <= EXP_W || DFRAC_W < FRAC_W)
         $error("mfw_widen: destination must be at least as wide as source");
      if (SUB_BASE - FRAC_W < 1)
         $error("mfw_widen: renormalized exponent would underflow");
   endgenerate

   logic              sign;
   logic [EXP_W-1:0]  exp_code;
   logic [FRAC_W-1:0] frac_code;
   mfw_class_e        cls;
   logic [DEXP_W-1:0] sub_exp;
   logic [FRAC_W-1:0] sub_frac;
   logic [OUT_W-1:0]  word_next;

   assign {sign, exp_code, frac_code} = in_byte;

   mfw_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .exp_code(exp_code), .frac_code(frac_code), .cls(cls));

   mfw_subnorm #(.FRAC_W(FRAC_W), .DEXP_W(DEXP_W), .SUB_BASE(SUB_BASE)) u_sub (
      .frac_code(frac_code), .exp_out(sub_exp), .frac_out(sub_frac));

   mfw_pack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .DEXP_W(DEXP_W),
              .DFRAC_W(DFRAC_W), .BIAS_DIFF(BIAS_DIFF)) u_pack (
      .sign(sign), .exp_code(exp_code), .frac_code(frac_code), .cls(cls),
      .sub_exp(sub_exp), .sub_frac(sub_frac), .word(word_next));

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_word  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) out_word <= word_next;
      end
   end

   localparam int LOW_W = DFRAC_W - FRAC_W + 1;

   assert_sign_copy_R1: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_word[OUT_W-1] == $past(in_byte[IN_W-1]));

   assert_rebias_R2: assert property (@(posedge clk) disable iff (rst)
      (in_valid && exp_code != '0 && exp_code != {EXP_W{1'b1}}) |=>
      out_word[OUT_W-2 -: DEXP_W] == DEXP_W'($past(exp_code)) + DEXP_W'(BIAS_DIFF));

   assert_zero_R4: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_byte[IN_W-2:0] == '0) |=> out_word[OUT_W-2:0] == '0);

   assert_nan_R6: assert property (@(posedge clk) disable iff (rst)
      (in_valid && exp_code == {EXP_W{1'b1}}) |=>
      (out_word[OUT_W-2 -: DEXP_W] == {DEXP_W{1'b1}} && out_word[DFRAC_W-1]));

   assert_sub_exp_R5: assert property (@(posedge clk) disable iff (rst)
      (in_valid && exp_code == '0 && frac_code != '0) |=>
      (out_word[OUT_W-2 -: DEXP_W] < DEXP_W'(SUB_BASE) &&
       out_word[OUT_W-2 -: DEXP_W] >= DEXP_W'(SUB_BASE - FRAC_W)));

   assert_low_zero_R3: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_byte[IN_W-2:0] != '0) |=> out_word[LOW_W-2:0] == '0);

   assert_valid_follow_R7: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);

   assert_valid_drop_R7: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);

   assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(out_word));
endmodule

// File: tb/mfw_widen_test.sv
`timescale 1ns/1ps
module mfw_widen_test;
   localparam real HALF = 2.0;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [7:0]  in_byte = 8'h00;
   logic        out_valid;
   logic [31:0] out_word;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic        exp_valid = 1'b0;
   logic [31:0] exp_word  = 32'h0;
   logic [7:0]  last_in   = 8'h00;

   always #(HALF) clk = ~clk;

   mfw_widen uut (.clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
                  .out_valid(out_valid), .out_word(out_word));

   function automatic logic [31:0] model(input logic [7:0] b);
      int s = b[7];
      int e = b[6:4];
      int f = b[3:0];
      int m, sh, oe, of;
      if (e == 7) begin
         oe = 255; of = 8 + (f % 8);
      end else if (e == 0 && f == 0) begin
         oe = 0; of = 0;
      end else if (e == 0) begin
         m = f; sh = 0;
         while (m < 16) begin m = m * 2; sh++; end
         oe = 125 - sh; of = m - 16;
      end else begin
         oe = e + 124; of = f;
      end
      return (32'(s) << 31) | (32'(oe) << 23) | (32'(of) << 19);
   endfunction

   function automatic string tag_exp(input logic [7:0] b);
      if (b[6:4] == 3'b111) return "R6";
      if (b[6:0] == 7'd0)   return "R4";
      if (b[6:4] == 3'b000) return "R5";
      return "R2";
   endfunction

   function automatic string tag_frac(input logic [7:0] b);
      if (b[6:4] == 3'b111) return "R6";
      if (b[6:0] == 7'd0)   return "R4";
      if (b[6:4] == 3'b000) return "R5";
      return "R3";
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (act !== expv) begin
         errors++;
         $display("FAIL %s in=%02h actual=%08h expected=%08h", tag, last_in, act, expv);
      end
   endtask

   // drive at negedge, let the edge pass, compare at the following negedge
   task automatic cycle(input logic r, input logic v, input logic [7:0] d);
      rst = r; in_valid = v; in_byte = d;
      @(posedge clk);
      if (r) begin
         exp_valid = 1'b0; exp_word = 32'h0;
      end else begin
         exp_valid = v;
         if (v) begin exp_word = model(d); last_in = d; end
      end
      @(negedge clk);
      if (r) begin
         chk("R9", {31'b0, out_valid}, 32'h0);
         chk("R9", out_word, 32'h0);
      end else begin
         chk("R7", {31'b0, out_valid}, {31'b0, exp_valid});
         if (v) begin
            chk("R1", {31'b0, out_word[31]}, {31'b0, exp_word[31]});
            chk(tag_exp(d), {24'b0, out_word[30:23]}, {24'b0, exp_word[30:23]});
            chk(tag_frac(d), {9'b0, out_word[22:0]}, {9'b0, exp_word[22:0]});
         end else begin
            chk("R8", out_word, exp_word);
         end
      end
   endtask

   initial begin
      @(negedge clk);
      cycle(1'b1, 1'b0, 8'h00);
      cycle(1'b1, 1'b1, 8'h35);
      // every code back to back
      for (int i = 0; i < 256; i++) cycle(1'b0, 1'b1, 8'(i));
      // every code with an idle cycle whose byte differs
      for (int i = 0; i < 256; i++) begin
         cycle(1'b0, 1'b1, 8'(255 - i));
         cycle(1'b0, 1'b0, 8'(i));
      end
      // hand-computed corner values
      cycle(1'b0, 1'b1, 8'h08); chk("R5", out_word, 32'h3E00_0000);
      cycle(1'b0, 1'b1, 8'h81); chk("R5", out_word, 32'hBC80_0000);
      cycle(1'b0, 1'b1, 8'h7F); chk("R6", out_word, 32'h7FF8_0000);
      cycle(1'b0, 1'b1, 8'hF0); chk("R6", out_word, 32'hFFC0_0000);
      cycle(1'b0, 1'b1, 8'h30); chk("R2", out_word, 32'h3F80_0000);
      cycle(1'b0, 1'b1, 8'h80); chk("R4", out_word, 32'h8000_0000);
      cycle(1'b0, 1'b0, 8'h11); chk("R8", out_word, 32'h8000_0000);
      // reset while streaming
      cycle(1'b0, 1'b1, 8'h5A);
      cycle(1'b1, 1'b1, 8'h5A);
      cycle(1'b0, 1'b0, 8'h00);
      cycle(1'b0, 1'b1, 8'h6C);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(HALF * 2 * 20000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule